// File: doc/BRIEF.md
# Serial Programming Word Receiver

This block takes a three-wire serial programming stream (serial clock, serial data, load strobe) and turns it into the divider and control settings of a frequency synthesizer. Bits enter a 19-bit shift register on each rising edge of the serial clock while the load strobe is low, with the most significant bit sent first. When the load strobe then rises, the register contents go to one of two settings banks. The bit shifted in last picks the bank.

One bank holds the reference setting: a 14-bit reference division ratio and four single-bit controls (modulus select, phase polarity, monitor select, pump current). The other bank holds the main divider setting: an 11-bit main count and a 7-bit swallow count. All three serial lines are asynchronous to the core clock. They are synchronized, and their edges are detected in the core domain. A word whose ratio (reference or main) is below 3 is refused. The bank keeps its old contents and a sticky error flag is set.

Top module: `prog_word_rx`

## Requirements
- R1: After synchronous reset the outputs are: reference ratio 3, main count 3, swallow count 0, modulus select 1, phase polarity 1, monitor select 0, pump current 0, error flag 0.
- R2: On each rising serial-clock edge while the load strobe is low, one data bit enters the register, first bit sent ending up most significant. Serial-clock edges while the load strobe is high leave the register unchanged.
- R3: Transfer on a word whose last bit is 1 updates the reference bank. It leaves the divider bank unchanged.
- R4: Transfer on a word whose last bit is 0 updates the divider bank. It leaves the reference bank unchanged.
- R5: Reference word, in sending order: pump current, monitor select, phase polarity, modulus select, then the 14-bit ratio MSB first, then the control bit 1.
- R6: Divider word, in sending order: the 11-bit main count MSB first, then the 7-bit swallow count MSB first, then the control bit 0.
- R7: A reference word with ratio 3 is accepted. A reference word with ratio below 3 sets the error flag, and every reference output keeps its value.
- R8: A divider word with main count below 3 sets the error flag, and both divider outputs (swallow count included) keep their values.
- R9: Once set, the error flag stays high until reset, even when valid words load later.
- R10: The outputs change only on a rising load-strobe edge. The new values appear on the third rising core-clock edge after that load-strobe rise, and no earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe; transfer on rising edge |
| ref_ratio | output | 14 | Reference division ratio |
| mod_sel | output | 1 | Prescaler modulus select |
| phase_pol | output | 1 | Phase comparator polarity |
| mon_sel | output | 1 | Monitor output select |
| pump_hi | output | 1 | Charge pump high-current select |
| main_cnt | output | 11 | Main programmable count |
| swallow_cnt | output | 7 | Swallow count |
| cfg_err | output | 1 | Sticky out-of-range error |

## Verification
A change on any serial line passes through two synchronizer flops and one edge-history flop. The register action therefore happens on the third core edge after the change. The bench holds the data line stable for two core cycles before each serial-clock rise and holds each serial-clock level for three cycles, so every bit is captured exactly once. After each strobe rise the bench waits five cycles before it reads the banks. The latency check samples between edges: after the second edge it expects the old values, and after the third it expects the new ones.

// File: rtl/prog_word_pkg.sv
package prog_word_pkg;

    parameter int REF_W   = 14;
    parameter int MAIN_W  = 11;
    parameter int SWAL_W  = 7;
    parameter int FLAGS_W = 4;
    parameter int MIN_RATIO = 3;

    localparam int REF_BODY = REF_W + FLAGS_W;
    localparam int DIV_BODY = MAIN_W + SWAL_W;
    localparam int WORD_W   = 1 + ((REF_BODY > DIV_BODY) ? REF_BODY : DIV_BODY);

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic             pump_hi;
        logic             mon_sel;
        logic             phase_pol;
        logic             mod_sel;
        logic [REF_W-1:0] ratio;
    } ref_cfg_t;

    typedef struct packed {
        logic [MAIN_W-1:0] main_cnt;
        logic [SWAL_W-1:0] swal_cnt;
    } div_cfg_t;

    typedef enum logic {
        DEST_DIV = 1'b0,
        DEST_REF = 1'b1
    } dest_e;

    localparam ref_cfg_t REF_RESET = '{
        pump_hi: 1'b0, mon_sel: 1'b0, phase_pol: 1'b1, mod_sel: 1'b1,
        ratio: REF_W'(MIN_RATIO)
    };

    localparam div_cfg_t DIV_RESET = '{
        main_cnt: MAIN_W'(MIN_RATIO), swal_cnt: '0
    };

    function automatic dest_e word_dest(input word_t w);
        return dest_e'(w[0]);
    endfunction

    function automatic ref_cfg_t decode_ref(input word_t w);
        ref_cfg_t c;
        c.pump_hi   = w[WORD_W-1];
        c.mon_sel   = w[WORD_W-2];
        c.phase_pol = w[WORD_W-3];
        c.mod_sel   = w[WORD_W-4];
        c.ratio     = w[REF_W:1];
        return c;
    endfunction

    function automatic div_cfg_t decode_div(input word_t w);
        div_cfg_t c;
        c.main_cnt = w[WORD_W-1 -: MAIN_W];
        c.swal_cnt = w[SWAL_W:1];
        return c;
    endfunction

endpackage

// File: rtl/pw_sync.sv
module pw_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] rise_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] pipe;
    logic [WIDTH-1:0]             hist;

    always_ff @(posedge clk) begin
        if (rst) pipe[0] <= '0;
        else     pipe[0] <= async_i;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) pipe[s] <= '0;
                else     pipe[s] <= pipe[s-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) hist <= '0;
        else     hist <= pipe[LAST];
    end

    assign level_o = pipe[LAST];
    assign rise_o  = pipe[LAST] & ~hist;

    // A rise may not be reported on two consecutive cycles.
    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        |rise_o |=> ((rise_o & $past(rise_o)) == '0)) else $error("rise held");  // R10

endmodule

// File: rtl/pw_shift.sv
module pw_shift
    import prog_word_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sclk_rise_i,
    input  logic  le_level_i,
    input  logic  bit_i,
    output word_t word_o
);
    word_t sr;

    always_ff @(posedge clk) begin
        if (rst)
            sr <= '0;
        else if (sclk_rise_i && !le_level_i)
            sr <= {sr[WORD_W-2:0], bit_i};
    end

    assign word_o = sr;

    AST_NO_SHIFT_LE_HIGH: assert property (@(posedge clk) disable iff (rst)
        le_level_i |=> $stable(sr)) else $error("shift while strobe high");  // R2

    AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (sclk_rise_i && !le_level_i) |=> (sr[0] == $past(bit_i))) else $error("bit lost");  // R2

endmodule

// File: rtl/pw_banks.sv
module pw_banks
    import prog_word_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load_i,
    input  word_t    word_i,
    output ref_cfg_t ref_o,
    output div_cfg_t div_o,
    output logic     err_o
);
    ref_cfg_t ref_q;
    div_cfg_t div_q;
    logic     err_q;

    ref_cfg_t ref_new;
    div_cfg_t div_new;
    dest_e    dest;
    logic     ref_ok;
    logic     div_ok;
    logic     word_bad;

    always_comb begin
        ref_new  = decode_ref(word_i);
        div_new  = decode_div(word_i);
        dest     = word_dest(word_i);
        ref_ok   = ref_new.ratio >= REF_W'(MIN_RATIO);
        div_ok   = div_new.main_cnt >= MAIN_W'(MIN_RATIO);
        word_bad = (dest == DEST_REF) ? !ref_ok : !div_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q <= REF_RESET;
            div_q <= DIV_RESET;
            err_q <= 1'b0;
        end else if (load_i) begin
            if (word_bad)
                err_q <= 1'b1;
            else if (dest == DEST_REF)
                ref_q <= ref_new;
            else
                div_q <= div_new;
        end
    end

    assign ref_o = ref_q;
    assign div_o = div_q;
    assign err_o = err_q;

    AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> ($stable(ref_q) && $stable(div_q))) else $error("bank moved");  // R10

    AST_DIV_KEEP_ON_REF: assert property (@(posedge clk) disable iff (rst)
        (load_i && word_i[0]) |=> $stable(div_q)) else $error("divider touched");  // R3

    AST_REF_KEEP_ON_DIV: assert property (@(posedge clk) disable iff (rst)
        (load_i && !word_i[0]) |=> $stable(ref_q)) else $error("reference touched");  // R4

    AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (load_i && word_bad) |=> ($stable(ref_q) && $stable(div_q) && err_q)) else $error("bad word taken");  // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q) else $error("error cleared");  // R9

    AST_RATIO_FLOOR: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (ref_q.ratio >= REF_W'(MIN_RATIO) && div_q.main_cnt >= MAIN_W'(MIN_RATIO)))
        else $error("ratio below floor");  // R8

endmodule

// File: rtl/prog_word_rx.sv
module prog_word_rx
    import prog_word_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_le,
    output logic [REF_W-1:0]  ref_ratio,
    output logic              mod_sel,
    output logic              phase_pol,
    output logic              mon_sel,
    output logic              pump_hi,
    output logic [MAIN_W-1:0] main_cnt,
    output logic [SWAL_W-1:0] swallow_cnt,
    output logic              cfg_err
);
    localparam int IDX_CLK = 0;
    localparam int IDX_DAT = 1;
    localparam int IDX_LE  = 2;
    localparam int N_LINES = 3;

    logic [N_LINES-1:0] lines_async;
    logic [N_LINES-1:0] lines_lvl;
    logic [N_LINES-1:0] lines_rise;
    word_t              shift_word;
    ref_cfg_t           ref_cfg;
    div_cfg_t           div_cfg;

    assign lines_async[IDX_CLK] = ser_clk;
    assign lines_async[IDX_DAT] = ser_dat;
    assign lines_async[IDX_LE]  = ser_le;

    pw_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (lines_async),
        .level_o (lines_lvl),
        .rise_o  (lines_rise)
    );

    pw_shift u_shift (
        .clk         (clk),
        .rst         (rst),
        .sclk_rise_i (lines_rise[IDX_CLK]),
        .le_level_i  (lines_lvl[IDX_LE]),
        .bit_i       (lines_lvl[IDX_DAT]),
        .word_o      (shift_word)
    );

    pw_banks u_banks (
        .clk    (clk),
        .rst    (rst),
        .load_i (lines_rise[IDX_LE]),
        .word_i (shift_word),
        .ref_o  (ref_cfg),
        .div_o  (div_cfg),
        .err_o  (cfg_err)
    );

    assign ref_ratio   = ref_cfg.ratio;
    assign mod_sel     = ref_cfg.mod_sel;
    assign phase_pol   = ref_cfg.phase_pol;
    assign mon_sel     = ref_cfg.mon_sel;
    assign pump_hi     = ref_cfg.pump_hi;
    assign main_cnt    = div_cfg.main_cnt;
    assign swallow_cnt = div_cfg.swal_cnt;

endmodule

// File: tb/prog_word_rx_tb.sv
module prog_word_rx_tb;
    import prog_word_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0;
    logic ser_dat = 1'b0;
    logic ser_le  = 1'b0;
    logic [REF_W-1:0]  ref_ratio;
    logic              mod_sel, phase_pol, mon_sel, pump_hi, cfg_err;
    logic [MAIN_W-1:0] main_cnt;
    logic [SWAL_W-1:0] swallow_cnt;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    prog_word_rx u_dut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le),
        .ref_ratio(ref_ratio), .mod_sel(mod_sel), .phase_pol(phase_pol), .mon_sel(mon_sel),
        .pump_hi(pump_hi), .main_cnt(main_cnt), .swallow_cnt(swallow_cnt), .cfg_err(cfg_err)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [WORD_W-1:0] w);
        for (int i = WORD_W - 1; i >= 0; i--) begin
            ser_dat = w[i];
            idle(2);
            ser_clk = 1'b1;
            idle(3);
            ser_clk = 1'b0;
            idle(3);
        end
    endtask

    task automatic strobe();
        ser_le = 1'b1;
        idle(5);
        ser_le = 1'b0;
        idle(3);
    endtask

    function automatic logic [WORD_W-1:0] ref_word(input logic pc, input logic ms,
            input logic pp, input logic md, input logic [REF_W-1:0] r);
        return {pc, ms, pp, md, r, 1'b1};
    endfunction

    function automatic logic [WORD_W-1:0] div_word(input logic [MAIN_W-1:0] n,
            input logic [SWAL_W-1:0] a);
        return {n, a, 1'b0};
    endfunction

    task automatic expect_ref(input string req, input int r, input logic pc, input logic ms,
            input logic pp, input logic md);
        chk(req, "ref_ratio", int'(ref_ratio), r);
        chk(req, "pump_hi",   int'(pump_hi),   int'(pc));
        chk(req, "mon_sel",   int'(mon_sel),   int'(ms));
        chk(req, "phase_pol", int'(phase_pol), int'(pp));
        chk(req, "mod_sel",   int'(mod_sel),   int'(md));
    endtask

    task automatic expect_div(input string req, input int n, input int a);
        chk(req, "main_cnt",    int'(main_cnt),    n);
        chk(req, "swallow_cnt", int'(swallow_cnt), a);
    endtask

    task automatic t_reset();
        expect_ref("R1", 3, 1'b0, 1'b0, 1'b1, 1'b1);
        expect_div("R1", 3, 0);
        chk("R1", "cfg_err", int'(cfg_err), 0);
    endtask

    task automatic t_ref_load();
        shift_bits(ref_word(1'b1, 1'b1, 1'b0, 1'b0, 14'd10843));
        strobe();
        expect_ref("R3_R5", 10843, 1'b1, 1'b1, 1'b0, 1'b0);
        expect_div("R3", 3, 0);
        shift_bits(ref_word(1'b0, 1'b1, 1'b0, 1'b1, 14'd16383));
        strobe();
        expect_ref("R5", 16383, 1'b0, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_div_load();
        shift_bits(div_word(11'd1443, 7'd85));
        strobe();
        expect_div("R4_R6", 1443, 85);
        expect_ref("R4", 16383, 1'b0, 1'b1, 1'b0, 1'b1);
        shift_bits(div_word(11'd2047, 7'd127));
        strobe();
        expect_div("R6", 2047, 127);
    endtask

    task automatic t_le_high_ignored();
        shift_bits(ref_word(1'b1, 1'b0, 1'b1, 1'b0, 14'd100));
        ser_le = 1'b1;
        idle(5);
        shift_bits(ref_word(1'b0, 1'b1, 1'b0, 1'b1, 14'd200));
        chk("R2", "ratio while strobe high", int'(ref_ratio), 100);
        ser_le = 1'b0;
        idle(3);
        strobe();
        expect_ref("R2", 100, 1'b1, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_latency();
        shift_bits(div_word(11'd500, 7'd9));
        @(negedge clk);
        ser_le = 1'b1;
        idle(2);
        chk("R10", "main_cnt after 2 edges", int'(main_cnt), 2047);
        idle(1);
        chk("R10", "main_cnt after 3 edges", int'(main_cnt), 500);
        idle(3);
        ser_le = 1'b0;
        idle(3);
    endtask

    task automatic t_range();
        shift_bits(ref_word(1'b0, 1'b0, 1'b0, 1'b0, 14'd3));
        strobe();
        expect_ref("R7", 3, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R7", "cfg_err at ratio 3", int'(cfg_err), 0);
        shift_bits(ref_word(1'b1, 1'b1, 1'b1, 1'b1, 14'd2));
        strobe();
        expect_ref("R7", 3, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R7", "cfg_err at ratio 2", int'(cfg_err), 1);
        shift_bits(div_word(11'd2, 7'd33));
        strobe();
        expect_div("R8", 500, 9);
        shift_bits(div_word(11'd77, 7'd4));
        strobe();
        expect_div("R9", 77, 4);
        chk("R9", "cfg_err sticky", int'(cfg_err), 1);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        idle(4);
        rst = 1'b0;
        idle(2);
        t_reset();
        t_ref_load();
        t_div_load();
        t_le_high_ignored();
        t_latency();
        t_range();
        finish_run();
    end

endmodule